// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a bank of 32-bit configuration registers inside a 4 KB window that is addressed by word. A simple bus reaches it. Each request is a one-cycle valid strobe with a write flag, a 10-bit word address and 32-bit write data. Read data and an error pulse come back one cycle later.

Most stored registers are protected by a lock. The bank comes out of reset locked. To allow ordinary writes, a 16-bit unlock key must be written to a dedicated unlock register. Writing a different 16-bit key to a dedicated lock register protects the bank again. Every offset has a fixed access class: read-write, read-only, write-only or unmapped. An access that breaks its class, or that is blocked by the lock, produces a one-cycle error pulse.

One register controls reset. A write to it that is accepted and has bit 0 set produces a one-cycle system reset request. A one-bit scratch register stays writable at all times.

Top module: `cfgbank_top`

## Requirements
- R1: After reset the bank is locked. The three PLL control words at byte offsets 0x100, 0x104 and 0x108 read 0x0001A008. The UART clock word at 0x154 reads 0x00003F03. The reset-control word at 0x200 and the scratch word at 0x000 read 0.
- R2: A write to the lock register at byte 0x004 sets the lock only when data[15:0] is 0x767B. Any other value leaves the lock state as it was. The write raises no error either way.
- R3: A write to the unlock register at byte 0x008 clears the lock only when data[15:0] is 0xDF0D. Any other value leaves the lock state as it was. The write raises no error either way.
- R4: A read of the lock-status register at byte 0x00C returns 1 in bit 0 when locked and 0 when unlocked. All other bits read 0.
- R5: While the bank is locked, a write to any read-write word other than the scratch word is discarded and raises the error pulse. Writes to the scratch, lock and unlock registers still take effect.
- R6: While the bank is unlocked, a write to a read-write word stores all 32 bits and raises no error. A read issued in the next request slot returns the new value.
- R7: The scratch word at 0x000 keeps only bit 0 of the write data. Bits 31:1 always read 0.
- R8: A write to a read-only offset (0x00C, 0x10C, 0x25C, 0x530) or to an unmapped offset changes nothing and raises the error pulse. PLL status at 0x10C reads 0x0000003F. The ID word at 0x530 reads the ID_WORD parameter.
- R9: A read of a write-only offset (0x004, 0x008) or of an unmapped offset returns 0 and raises the error pulse.
- R10: An accepted write to 0x200 with data bit 0 set drives sys_reset_req high for exactly the one cycle after the write. A write that is locked out, or that has bit 0 clear, produces no request.
- R11: bus_rdata and bus_err are registered and appear in the cycle after the request. bus_err is high for one cycle per illegal access and low for legal accesses. bus_rdata is 0 in cycles that follow no read.
- R12: A read of the boot-mode register at 0x25C returns the 4-bit boot strap input in bits 3:0 and 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| boot_strap | input | 4 | Boot mode strap pins |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | One-cycle pulse for an illegal or locked-out access |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
A wrong lock state shows at the ports one cycle after the next access to a protected word. Either a locked-out write fails to raise bus_err, or a write that should pass raises it. Reading 0x00C exposes the lock state directly. A bad access-class decode shows up as a wrong error bit or wrong data on the first read or write of the affected offset, which is why every word offset is swept both locked and unlocked. A corrupted stored word shows on its first read-back, and a stray or stretched reset request shows in the cycle that follows the write.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  // width of the index into the read-write storage array
  localparam int unsigned IDX_W = 3;

  // word offsets whose position is part of the software contract
  localparam int unsigned W_SCRATCH = 32'h000;
  localparam int unsigned W_LOCK    = 32'h001;
  localparam int unsigned W_UNLOCK  = 32'h002;
  localparam int unsigned W_LOCKSTA = 32'h003;
  localparam int unsigned W_PLL0    = 32'h040;  // first PLL control word
  localparam int unsigned W_PLLSTA  = 32'h043;
  localparam int unsigned W_UARTCLK = 32'h055;
  localparam int unsigned W_RSTCTL  = 32'h080;
  localparam int unsigned W_BOOT    = 32'h097;
  localparam int unsigned W_IDCODE  = 32'h14C;

  typedef enum logic [3:0] {
    K_NONE,
    K_SCRATCH,
    K_LOCK,
    K_UNLOCK,
    K_LOCKSTA,
    K_PLLSTA,
    K_BOOT,
    K_IDCODE,
    K_RW
  } kind_e;

endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_PLL = 3   // at most 3: the PLL status word follows them
) (
  input  logic [ADDR_W-1:0] addr,
  output kind_e             kind,
  output logic [IDX_W-1:0]  idx
);

  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    kind = K_NONE;
    idx  = '0;
    case (a32)
      W_SCRATCH: kind = K_SCRATCH;
      W_LOCK:    kind = K_LOCK;
      W_UNLOCK:  kind = K_UNLOCK;
      W_LOCKSTA: kind = K_LOCKSTA;
      W_PLLSTA:  kind = K_PLLSTA;
      W_BOOT:    kind = K_BOOT;
      W_IDCODE:  kind = K_IDCODE;
      W_UARTCLK: begin
        kind = K_RW;
        idx  = IDX_W'(NUM_PLL);
      end
      W_RSTCTL: begin
        kind = K_RW;
        idx  = IDX_W'(NUM_PLL + 1);
      end
      default: ;
    endcase
    for (int p = 0; p < NUM_PLL; p++) begin
      if (a32 == W_PLL0 + 32'(p)) begin
        kind = K_RW;
        idx  = IDX_W'(p);
      end
    end
  end

endmodule

// File: rtl/cfgbank_lock.sv
module cfgbank_lock #(
  parameter int unsigned KEY_W      = 16,
  parameter logic [KEY_W-1:0] LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_we,
  input  logic             unlock_we,
  input  logic [KEY_W-1:0] key,
  output logic             locked
);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b1;
    end else if (lock_we && key == LOCK_KEY) begin
      locked <= 1'b1;
    end else if (unlock_we && key == UNLOCK_KEY) begin
      locked <= 1'b0;
    end
  end

endmodule

// File: rtl/cfgbank_regs.sv
module cfgbank_regs
  import cfgbank_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_PLL = 3,
  parameter int unsigned NUM_RW  = NUM_PLL + 2,
  parameter logic [DATA_W-1:0] PLL_RST  = 32'h0001_A008,
  parameter logic [DATA_W-1:0] UART_RST = 32'h0000_3F03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q [NUM_RW]
);

  for (genvar g = 0; g < NUM_RW; g++) begin : g_word
    localparam logic [DATA_W-1:0] RV =
      (g < NUM_PLL) ? PLL_RST : ((g == NUM_PLL) ? UART_RST : '0);
    always_ff @(posedge clk) begin
      if (rst) begin
        q[g] <= RV;
      end else if (we && idx == IDX_W'(g)) begin
        q[g] <= wdata;
      end
    end
  end

endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned KEY_W   = 16,
  parameter int unsigned NUM_PLL = 3,
  parameter int unsigned BOOT_W  = 4,
  parameter logic [KEY_W-1:0]  LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0]  UNLOCK_KEY = 16'hDF0D,
  parameter logic [DATA_W-1:0] PLL_RESET  = 32'h0001_A008,
  parameter logic [DATA_W-1:0] UART_RESET = 32'h0000_3F03,
  parameter logic [DATA_W-1:0] PLL_STATUS = 32'h0000_003F,
  parameter logic [DATA_W-1:0] ID_WORD    = 32'h1372_3093
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [BOOT_W-1:0] boot_strap,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              sys_reset_req
);

  localparam int unsigned NUM_RW  = NUM_PLL + 2;
  localparam int unsigned RST_IDX = NUM_PLL + 1;

  kind_e             kind;
  logic [IDX_W-1:0]  idx;
  logic              locked;
  logic              scratch;
  logic              wr, rd, is_rw, rw_we;
  logic              wr_bad, rd_bad;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] q [NUM_RW];

  assign wr    = bus_valid && bus_write;
  assign rd    = bus_valid && !bus_write;
  assign is_rw = (kind == K_RW);
  assign rw_we = wr && is_rw && !locked;

  cfgbank_decode #(.ADDR_W(ADDR_W), .NUM_PLL(NUM_PLL)) u_dec (
    .addr (bus_addr),
    .kind (kind),
    .idx  (idx)
  );

  cfgbank_lock #(.KEY_W(KEY_W), .LOCK_KEY(LOCK_KEY), .UNLOCK_KEY(UNLOCK_KEY)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .lock_we   (wr && kind == K_LOCK),
    .unlock_we (wr && kind == K_UNLOCK),
    .key       (bus_wdata[KEY_W-1:0]),
    .locked    (locked)
  );

  cfgbank_regs #(
    .DATA_W(DATA_W), .NUM_PLL(NUM_PLL), .NUM_RW(NUM_RW),
    .PLL_RST(PLL_RESET), .UART_RST(UART_RESET)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (rw_we),
    .idx   (idx),
    .wdata (bus_wdata),
    .q     (q)
  );

  // scratch bit is outside the lock
  always_ff @(posedge clk) begin
    if (rst) begin
      scratch <= 1'b0;
    end else if (wr && kind == K_SCRATCH) begin
      scratch <= bus_wdata[0];
    end
  end

  assign wr_bad = wr && ((kind inside {K_NONE, K_LOCKSTA, K_PLLSTA, K_BOOT, K_IDCODE})
                         || (is_rw && locked));
  assign rd_bad = rd && (kind inside {K_NONE, K_LOCK, K_UNLOCK});

  always_comb begin
    rd_mux = '0;
    case (kind)
      K_SCRATCH: rd_mux = DATA_W'(scratch);
      K_LOCKSTA: rd_mux = DATA_W'(locked);
      K_PLLSTA:  rd_mux = PLL_STATUS;
      K_BOOT:    rd_mux = DATA_W'(boot_strap);
      K_IDCODE:  rd_mux = ID_WORD;
      K_RW:      if (32'(idx) < NUM_RW) rd_mux = q[idx];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata     <= '0;
      bus_err       <= 1'b0;
      sys_reset_req <= 1'b0;
    end else begin
      bus_rdata     <= rd ? rd_mux : '0;
      bus_err       <= wr_bad || rd_bad;
      sys_reset_req <= rw_we && (idx == IDX_W'(RST_IDX)) && bus_wdata[0];
    end
  end

endmodule

// File: rtl/cfgbank_check.sv
module cfgbank_check
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned KEY_W  = 16,
  parameter int unsigned BOOT_W = 4,
  parameter logic [KEY_W-1:0] LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [KEY_W-1:0]  wdata_lo,
  input logic [BOOT_W-1:0] boot_strap,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              sys_reset_req,
  input logic              locked,
  input logic              is_rw
);

  assert_start_locked_R1: assert property (@(posedge clk) rst |=> locked);

  assert_lock_key_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_addr == ADDR_W'(W_LOCK) && wdata_lo == LOCK_KEY) |=> locked);

  assert_unlock_key_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_addr == ADDR_W'(W_UNLOCK) && wdata_lo == UNLOCK_KEY) |=> !locked);

  assert_locked_write_err_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && is_rw && locked) |=> bus_err);

  assert_req_single_R10: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |=> !sys_reset_req);

  assert_req_source_R10: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> $past(bus_valid && bus_write && !locked && wdata_lo[0]
                            && bus_addr == ADDR_W'(W_RSTCTL)));

  assert_err_after_req_R11: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_valid));

  assert_boot_read_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(W_BOOT))
      |=> bus_rdata == DATA_W'($past(boot_strap)));

endmodule

bind cfgbank_top cfgbank_check #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W), .BOOT_W(BOOT_W),
  .LOCK_KEY(LOCK_KEY), .UNLOCK_KEY(UNLOCK_KEY)
) u_check (
  .clk           (clk),
  .rst           (rst),
  .bus_valid     (bus_valid),
  .bus_write     (bus_write),
  .bus_addr      (bus_addr),
  .wdata_lo      (bus_wdata[KEY_W-1:0]),
  .boot_strap    (boot_strap),
  .bus_rdata     (bus_rdata),
  .bus_err       (bus_err),
  .sys_reset_req (sys_reset_req),
  .locked        (locked),
  .is_rw         (is_rw)
);

// File: tb/test_cfgbank_top.sv
module test_cfgbank_top;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] ID_VAL = 32'h1372_3093;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  boot_strap = 4'h9;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        sys_reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural model of the requirements
  logic        m_locked;
  logic        m_scratch;
  logic [31:0] m_rw [5];  // 0..2 PLL, 3 UART clock, 4 reset control

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgbank_top #(.ID_WORD(ID_VAL)) i_cfgbank_top (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .boot_strap(boot_strap),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .sys_reset_req(sys_reset_req)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int rw_slot(input int off);
    case (off)
      32'h100: return 0;
      32'h104: return 1;
      32'h108: return 2;
      32'h154: return 3;
      32'h200: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic string read_tag(input int off, input string rw_tag);
    if (rw_slot(off) >= 0) return rw_tag;
    case (off)
      32'h000: return "R7";
      32'h00C: return "R4";
      32'h10C, 32'h530: return "R8";
      32'h25C: return "R12";
      default: return "R9";
    endcase
  endfunction

  function automatic void exp_read(input int off, output logic [31:0] d, output logic e);
    d = '0;
    e = 1'b0;
    if (rw_slot(off) >= 0) d = m_rw[rw_slot(off)];
    else case (off)
      32'h000: d = {31'b0, m_scratch};
      32'h00C: d = {31'b0, m_locked};
      32'h10C: d = 32'h0000_003F;
      32'h25C: d = {28'b0, boot_strap};
      32'h530: d = ID_VAL;
      default: e = 1'b1;
    endcase
  endfunction

  task automatic model_write(input int off, input logic [31:0] d,
                             output logic e, output logic q);
    e = 1'b0;
    q = 1'b0;
    if (rw_slot(off) >= 0) begin
      if (m_locked) e = 1'b1;
      else begin
        m_rw[rw_slot(off)] = d;
        q = (off == 32'h200) && d[0];
      end
    end else case (off)
      32'h000: m_scratch = d[0];
      32'h004: if (d[15:0] == 16'h767B) m_locked = 1'b1;
      32'h008: if (d[15:0] == 16'hDF0D) m_locked = 1'b0;
      default: e = 1'b1;
    endcase
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; e = bus_err;
    bus_valid = 1'b0;
  endtask

  // write, then sample the response cycle and the following idle cycle
  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d, input string tag);
    logic ee, eq;
    model_write(int'(a) * 4, d, ee, eq);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    check(bus_err == ee, {tag, " write error flag"}, 32'(bus_err), 32'(ee));
    check(sys_reset_req == eq, "R10 reset request", 32'(sys_reset_req), 32'(eq));
    bus_valid = 1'b0; bus_write = 1'b0;
    @(negedge clk);
    check(bus_err == 1'b0, "R11 error pulse width", 32'(bus_err), 32'd0);
    check(sys_reset_req == 1'b0, "R10 request one cycle", 32'(sys_reset_req), 32'd0);
    check(bus_rdata == '0, "R11 idle read data", bus_rdata, 32'd0);
  endtask

  task automatic read_sweep(input string rw_tag);
    logic [31:0] d, ed;
    logic e, ee;
    for (int a = 0; a < 1024; a++) begin
      exp_read(a * 4, ed, ee);
      bus_rd(10'(a), d, e);
      check(d == ed, {read_tag(a * 4, rw_tag), " read data"}, d, ed);
      check(e == ee, {read_tag(a * 4, rw_tag), " read error"}, 32'(e), 32'(ee));
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    return (32'h5A00_0000 ^ (32'(a) * 32'h0001_0401)) | 32'(a == 0);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    m_locked  = 1'b1;
    m_scratch = 1'b0;
    m_rw[0] = 32'h0001_A008; m_rw[1] = 32'h0001_A008; m_rw[2] = 32'h0001_A008;
    m_rw[3] = 32'h0000_3F03; m_rw[4] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state over the whole map
    read_sweep("R1");

    // R5/R8: locked write sweep, then nothing but scratch may change
    for (int a = 0; a < 1024; a++) bus_wr(10'(a), 32'hC3C3_0000 | 32'(a), "R5");
    read_sweep("R5");

    // R3: wrong unlock key ignored
    bus_wr(10'h002, 32'h0000_1234, "R3");
    bus_rd(10'h003, d, e);
    check(d == 32'd1, "R3 wrong unlock key ignored", d, 32'd1);
    bus_wr(10'h002, 32'hFFFF_DF0D, "R3");
    bus_rd(10'h003, d, e);
    check(d == 32'd0, "R3 unlock with key", d, 32'd0);

    // R6/R7/R8: unlocked write sweep and read-back
    for (int a = 0; a < 1024; a++) bus_wr(10'(a), pat(a), "R6");
    read_sweep("R6");
    bus_wr(10'h000, 32'hFFFF_FFFE, "R7");
    bus_rd(10'h000, d, e);
    check(d == 32'd0, "R7 scratch bit 0 only", d, 32'd0);

    // R10: accepted reset request, then a bit-0-clear write
    bus_wr(10'h080, 32'h0000_0001, "R10");
    bus_wr(10'h080, 32'h8000_0000, "R10");

    // R2: wrong lock key ignored, correct one locks
    bus_wr(10'h001, 32'h767A_0000, "R2");
    bus_rd(10'h003, d, e);
    check(d == 32'd0, "R2 wrong lock key ignored", d, 32'd0);
    bus_wr(10'h001, 32'h0000_767B, "R2");
    bus_rd(10'h003, d, e);
    check(d == 32'd1, "R2 lock with key", d, 32'd1);
    check(e == 1'b0, "R4 status read no error", 32'(e), 32'd0);

    // R10: locked-out reset write produces no request
    bus_wr(10'h080, 32'hFFFF_FFFF, "R10");
    bus_rd(10'h080, d, e);
    check(d == 32'h8000_0000, "R10 locked reset write discarded", d, 32'h8000_0000);

    // R12: every strap value
    for (int s = 0; s < 16; s++) begin
      boot_strap = 4'(s);
      bus_rd(10'h097, d, e);
      check(d == 32'(s), "R12 boot strap", d, 32'(s));
      check(e == 1'b0, "R12 boot read no error", 32'(e), 32'd0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule